// File: doc/BRIEF.md
# Transmit Descriptor Ring Engine

This block owns a small table of buffer descriptors that the host fills through a 32-bit register bus. The leading part of the table forms a ring of transmit descriptors. Its length is set by a count register, and the entries after the ring are left for receive use. An engine walks the ring one entry at a time. When it finds an entry whose ready flag is set, and transmission is enabled, it presents that entry's buffer address, byte length and per-frame options to a downstream frame transmitter. It then waits for the transmitter to finish.

When the transmitter reports completion with a result vector, the engine writes the result into the low bits of the descriptor's status word and clears the ready flag, which returns the entry to the host. If the entry asked for an interrupt, the engine raises either a frame-sent or a transmit-error source bit. A mask register gates the source bits onto a single interrupt line. The host clears a source bit by writing a 1 to it.

Top module: `txbd_engine`

## Requirements
- R1: After reset, tx_req and irq are 0, and the control, interrupt source, interrupt mask and count registers all read as 0.
- R2: Descriptor entry i holds its status word at byte address 0x400+8*i and its buffer address at 0x404+8*i. A host read returns the stored value one cycle after the address is presented. An entry index of NUM_BD or above reads 0, and writes to it are ignored.
- R3: The ring-length register at 0x00C stores the written value, except that any value above NUM_BD is stored as NUM_BD.
- R4: No frame starts while bit 1 of the control register at 0x000 is 0, and a ready descriptor is left unchanged during that time.
- R5: When enabled, the engine raises tx_req for a descriptor at the current ring index whose status bit 15 (ready) is 1. It drives tx_addr from the address word, tx_len from status bits 31:16, tx_pad from bit 12 and tx_crc from bit 11.
- R6: tx_req and its fields stay constant until tx_done is seen, and tx_req is 0 in the cycle after tx_done.
- R7: On completion the status word is written back with bit 15 cleared, bits 8:0 replaced by tx_result, and all other bits unchanged.
- R8: A completion sets an interrupt source bit only when status bit 14 of the descriptor is 1.
- R9: Writing a 1 to a bit of the source register at 0x004 clears that bit. Writing 0 leaves it unchanged.
- R10: A completion whose result has bit 3 (retry limit), bit 2 (late collision) or bit 8 (underrun) set sets source bit 1 (error). Any other completion sets source bit 0 (sent).
- R11: irq is 1 exactly when some source bit and the same bit of the mask register at 0x008 are both 1.
- R12: After serving index i, the engine moves to index 0 if status bit 13 (wrap) was set or i equals count-1. Otherwise it moves to i+1.
- R13: Descriptors at an index equal to or above the ring-length register are never served.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Host write strobe |
| bus_addr | input | 12 | Host byte address |
| bus_wdata | input | 32 | Host write data |
| bus_rdata | output | 32 | Host read data, valid one cycle after address |
| tx_req | output | 1 | Frame request to the transmitter |
| tx_addr | output | 32 | Buffer address of the requested frame |
| tx_len | output | 16 | Byte length of the requested frame |
| tx_pad | output | 1 | Pad short frame option |
| tx_crc | output | 1 | Append CRC option |
| tx_done | input | 1 | Single-cycle completion pulse from the transmitter |
| tx_result | input | 9 | Completion result bits |
| irq | output | 1 | Masked interrupt |

## Verification
The bench builds the engine with NUM_BD set to 8. This keeps the table small enough that writes to the ring-length register can overshoot it and show the clamp, and that an index just past the table can be probed. A ring length of 3 lets one run reach every index advance: the step from i to i+1, the return after the last ring entry, and the return forced by a wrap flag. The entry just beyond the ring stays in reach to show that it is never served.

// File: rtl/txbd_pkg.sv
package txbd_pkg;
  localparam int BUS_AW = 12;
  localparam int RES_W  = 9;

  localparam logic [BUS_AW-1:0] OFF_CTRL = 12'h000;
  localparam logic [BUS_AW-1:0] OFF_SRC  = 12'h004;
  localparam logic [BUS_AW-1:0] OFF_MSK  = 12'h008;
  localparam logic [BUS_AW-1:0] OFF_CNT  = 12'h00C;

  localparam int CTRL_TXEN = 1;
  localparam int ST_READY  = 15;
  localparam int ST_IRQ    = 14;
  localparam int ST_WRAP   = 13;
  localparam int ST_PAD    = 12;
  localparam int ST_CRC    = 11;
  localparam int RES_LC    = 2;
  localparam int RES_RL    = 3;
  localparam int RES_UR    = 8;

  typedef enum logic [1:0] {W_FETCH, W_CHECK, W_SEND, W_WB} walk_state_e;

  function automatic logic result_is_error(input logic [RES_W-1:0] r);
    return r[RES_RL] | r[RES_LC] | r[RES_UR];
  endfunction
endpackage

// File: rtl/txbd_ram.sv
module txbd_ram #(
  parameter int DEPTH = 16,
  parameter int WIDTH = 32,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [AW-1:0]    ra_addr,
  input  logic [AW-1:0]    rb_addr,
  output logic [WIDTH-1:0] ra_q,
  output logic [WIDTH-1:0] rb_q
);
  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    ra_q <= mem[ra_addr];
    rb_q <= mem[rb_addr];
  end
endmodule

// File: rtl/txbd_regs.sv
module txbd_regs import txbd_pkg::*; #(
  parameter int NUM_BD = 16,
  localparam int CNT_W = $clog2(NUM_BD + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [BUS_AW-1:0] addr,
  input  logic [31:0]       wdata,
  input  logic              evt_valid,
  input  logic              evt_err,
  output logic              tx_en,
  output logic [CNT_W-1:0]  tx_cnt,
  output logic              irq,
  output logic [31:0]       rdata
);
  logic [1:0] src, msk, src_clr, src_set, src_next;

  always_comb begin
    src_clr  = (we && addr == OFF_SRC) ? wdata[1:0] : 2'b00;
    src_set  = evt_valid ? (evt_err ? 2'b10 : 2'b01) : 2'b00;
    src_next = (src & ~src_clr) | src_set;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_en  <= 1'b0;
      tx_cnt <= '0;
      msk    <= '0;
      src    <= '0;
      rdata  <= '0;
    end else begin
      src <= src_next;
      if (we && addr == OFF_CTRL) tx_en <= wdata[CTRL_TXEN];
      if (we && addr == OFF_MSK)  msk   <= wdata[1:0];
      if (we && addr == OFF_CNT)
        tx_cnt <= (wdata > 32'(NUM_BD)) ? CNT_W'(NUM_BD) : wdata[CNT_W-1:0];
      case (addr)
        OFF_CTRL: rdata <= 32'(tx_en) << CTRL_TXEN;
        OFF_SRC:  rdata <= 32'(src);
        OFF_MSK:  rdata <= 32'(msk);
        OFF_CNT:  rdata <= 32'(tx_cnt);
        default:  rdata <= '0;
      endcase
    end
  end

  assign irq = |(src & msk);

  p_cnt_bound_r3: assert property (@(posedge clk) disable iff (rst)
    32'(tx_cnt) <= 32'(NUM_BD));
  p_sent_set_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(src[0]) |-> $past(evt_valid && !evt_err));
  p_err_set_r10: assert property (@(posedge clk) disable iff (rst)
    $rose(src[1]) |-> $past(evt_valid && evt_err));
  p_w1c_r9: assert property (@(posedge clk) disable iff (rst)
    $fell(src[0]) |-> $past(we && addr == OFF_SRC && wdata[0]));
endmodule

// File: rtl/txbd_walker.sv
module txbd_walker import txbd_pkg::*; #(
  parameter int NUM_BD = 16,
  localparam int IDX_W = $clog2(NUM_BD),
  localparam int CNT_W = $clog2(NUM_BD + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tx_en,
  input  logic [CNT_W-1:0] tx_cnt,
  input  logic [31:0]      st_q,
  input  logic [31:0]      ad_q,
  input  logic             host_st_wr,
  input  logic             tx_done,
  input  logic [RES_W-1:0] tx_result,
  output logic [IDX_W-1:0] cur_idx,
  output logic             wb_we,
  output logic [31:0]      wb_data,
  output logic             tx_req,
  output logic [31:0]      tx_addr,
  output logic [15:0]      tx_len,
  output logic             tx_pad,
  output logic             tx_crc,
  output logic             evt_valid,
  output logic             evt_err
);
  walk_state_e      state;
  logic [31:0]      word;
  logic [RES_W-1:0] res;
  logic             last;

  assign last    = (CNT_W'(cur_idx) == tx_cnt - CNT_W'(1));
  assign wb_we   = (state == W_WB) && !host_st_wr;
  assign wb_data = {word[31:16], 1'b0, word[14:RES_W], res};
  assign evt_valid = wb_we && word[ST_IRQ];
  assign evt_err   = result_is_error(res);

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= W_FETCH;
      cur_idx <= '0;
      tx_req  <= 1'b0;
      word    <= '0;
      res     <= '0;
      tx_addr <= '0;
      tx_len  <= '0;
      tx_pad  <= 1'b0;
      tx_crc  <= 1'b0;
    end else begin
      case (state)
        W_FETCH: state <= W_CHECK;
        W_CHECK: begin
          if (CNT_W'(cur_idx) >= tx_cnt) begin
            cur_idx <= '0;
            state   <= W_FETCH;
          end else if (tx_en && st_q[ST_READY]) begin
            word    <= st_q;
            tx_addr <= ad_q;
            tx_len  <= st_q[31:16];
            tx_pad  <= st_q[ST_PAD];
            tx_crc  <= st_q[ST_CRC];
            tx_req  <= 1'b1;
            state   <= W_SEND;
          end else begin
            state <= W_FETCH;
          end
        end
        W_SEND: begin
          if (tx_done) begin
            res    <= tx_result;
            tx_req <= 1'b0;
            state  <= W_WB;
          end
        end
        W_WB: begin
          if (!host_st_wr) begin
            cur_idx <= (word[ST_WRAP] || last) ? '0 : cur_idx + IDX_W'(1);
            state   <= W_FETCH;
          end
        end
        default: state <= W_FETCH;
      endcase
    end
  end

  p_req_held_r6: assert property (@(posedge clk) disable iff (rst)
    tx_req && !tx_done |=> tx_req);
  p_fields_stable_r6: assert property (@(posedge clk) disable iff (rst)
    tx_req && !tx_done |=> $stable(tx_addr) && $stable(tx_len) && $stable(tx_pad) && $stable(tx_crc));
  p_req_drop_r6: assert property (@(posedge clk) disable iff (rst)
    tx_req && tx_done |=> !tx_req);
  p_start_needs_en_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(tx_req) |-> $past(tx_en));
  p_start_in_ring_r13: assert property (@(posedge clk) disable iff (rst)
    $rose(tx_req) |-> (CNT_W'($past(cur_idx)) < $past(tx_cnt)));
endmodule

// File: rtl/txbd_engine.sv
module txbd_engine import txbd_pkg::*; #(
  parameter int NUM_BD = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_we,
  input  logic [BUS_AW-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              tx_req,
  output logic [31:0]       tx_addr,
  output logic [15:0]       tx_len,
  output logic              tx_pad,
  output logic              tx_crc,
  input  logic              tx_done,
  input  logic [RES_W-1:0]  tx_result,
  output logic              irq
);
  localparam int IDX_W = $clog2(NUM_BD);
  localparam int CNT_W = $clog2(NUM_BD + 1);

  logic             in_tbl, word_sel, ent_ok, host_st_wr, host_ad_wr, reg_we;
  logic [6:0]       ent;
  logic [IDX_W-1:0] host_idx, cur_idx;
  logic             rd_tbl_q, rd_word_q, rd_ok_q;
  logic [31:0]      st_host_q, ad_host_q, st_eng_q, ad_eng_q, reg_rdata;
  logic             tx_en, wb_we, evt_valid, evt_err;
  logic [CNT_W-1:0] tx_cnt;
  logic [31:0]      wb_data;
  logic             st_we;
  logic [IDX_W-1:0] st_waddr;
  logic [31:0]      st_wdata;

  assign in_tbl     = (bus_addr[11:10] == 2'b01);
  assign ent        = bus_addr[9:3];
  assign word_sel   = bus_addr[2];
  assign ent_ok     = (ent < 7'(NUM_BD));
  assign host_idx   = ent[IDX_W-1:0];
  assign host_st_wr = bus_we && in_tbl && ent_ok && !word_sel;
  assign host_ad_wr = bus_we && in_tbl && ent_ok && word_sel;
  assign reg_we     = bus_we && !in_tbl;

  assign st_we    = host_st_wr || wb_we;
  assign st_waddr = host_st_wr ? host_idx : cur_idx;
  assign st_wdata = host_st_wr ? bus_wdata : wb_data;

  txbd_ram #(.DEPTH(NUM_BD), .WIDTH(32)) u_status (
    .clk(clk), .we(st_we), .waddr(st_waddr), .wdata(st_wdata),
    .ra_addr(host_idx), .rb_addr(cur_idx), .ra_q(st_host_q), .rb_q(st_eng_q));

  txbd_ram #(.DEPTH(NUM_BD), .WIDTH(32)) u_bufaddr (
    .clk(clk), .we(host_ad_wr), .waddr(host_idx), .wdata(bus_wdata),
    .ra_addr(host_idx), .rb_addr(cur_idx), .ra_q(ad_host_q), .rb_q(ad_eng_q));

  txbd_regs #(.NUM_BD(NUM_BD)) u_regs (
    .clk(clk), .rst(rst), .we(reg_we), .addr(bus_addr), .wdata(bus_wdata),
    .evt_valid(evt_valid), .evt_err(evt_err), .tx_en(tx_en), .tx_cnt(tx_cnt),
    .irq(irq), .rdata(reg_rdata));

  txbd_walker #(.NUM_BD(NUM_BD)) u_walker (
    .clk(clk), .rst(rst), .tx_en(tx_en), .tx_cnt(tx_cnt),
    .st_q(st_eng_q), .ad_q(ad_eng_q), .host_st_wr(host_st_wr),
    .tx_done(tx_done), .tx_result(tx_result), .cur_idx(cur_idx),
    .wb_we(wb_we), .wb_data(wb_data), .tx_req(tx_req), .tx_addr(tx_addr),
    .tx_len(tx_len), .tx_pad(tx_pad), .tx_crc(tx_crc),
    .evt_valid(evt_valid), .evt_err(evt_err));

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_tbl_q  <= 1'b0;
      rd_word_q <= 1'b0;
      rd_ok_q   <= 1'b0;
    end else begin
      rd_tbl_q  <= in_tbl;
      rd_word_q <= word_sel;
      rd_ok_q   <= ent_ok;
    end
  end

  always_comb begin
    if (!rd_tbl_q)     bus_rdata = reg_rdata;
    else if (!rd_ok_q) bus_rdata = '0;
    else               bus_rdata = rd_word_q ? ad_host_q : st_host_q;
  end

  p_no_wb_while_req_r7: assert property (@(posedge clk) disable iff (rst)
    wb_we |-> !tx_req);
endmodule

// File: tb/tb_txbd_engine.sv
module tb_txbd_engine;
  localparam int NB = 8;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_we = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        tx_req, tx_pad, tx_crc, irq;
  logic [31:0] tx_addr;
  logic [15:0] tx_len;
  logic        tx_done = 1'b0;
  logic [8:0]  tx_result = '0;

  int n_chk = 0;
  int n_err = 0;

  logic [1:0]  src_m = '0, mask_m = '0;
  logic        exp_on = 1'b0;
  logic [31:0] exp_addr;
  logic [15:0] exp_len;
  logic        exp_pad, exp_crc;

  always #2 clk = ~clk;

  txbd_engine #(.NUM_BD(NB)) dut (
    .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tx_req(tx_req),
    .tx_addr(tx_addr), .tx_len(tx_len), .tx_pad(tx_pad), .tx_crc(tx_crc),
    .tx_done(tx_done), .tx_result(tx_result), .irq(irq));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
  endtask

  task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    if (a == 12'h004) src_m = src_m & ~d[1:0];
    if (a == 12'h008) mask_m = d[1:0];
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic bus_read(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    @(negedge clk);
    d = bus_rdata;
  endtask

  task automatic read_chk(input string req, input logic [11:0] a, input logic [31:0] exp);
    logic [31:0] v;
    bus_read(a, v);
    chk(req, v, exp);
  endtask

  task automatic wait_req(input string req);
    int n = 0;
    while (!tx_req && n < 40) begin
      @(negedge clk);
      n++;
    end
    chk(req, 32'(tx_req), 32'd1);
    repeat (4) begin
      @(negedge clk);
      chk("R6 request held", 32'(tx_req), 32'd1);
    end
  endtask

  task automatic finish_frame(input logic [8:0] res, input logic ien);
    @(negedge clk);
    tx_done = 1'b1; tx_result = res;
    @(negedge clk);
    tx_done = 1'b0; exp_on = 1'b0;
    chk("R6 request dropped", 32'(tx_req), 32'd0);
    if (ien) begin
      if (res[3] | res[2] | res[8]) src_m[1] = 1'b1;
      else src_m[0] = 1'b1;
    end
  endtask

  task automatic expect_frame(input logic [31:0] a, input logic [15:0] l,
                              input logic p, input logic c);
    exp_addr = a; exp_len = l; exp_pad = p; exp_crc = c; exp_on = 1'b1;
  endtask

  // Per-clock comparison against the behavioural model
  always @(posedge clk) begin
    #1;
    if (!rst) begin
      chk("R11 irq vs model", 32'(irq), 32'(|(src_m & mask_m)));
      if (tx_req) begin
        chk("R5 request expected", 32'(exp_on), 32'd1);
        if (exp_on) begin
          chk("R5 tx_addr", tx_addr, exp_addr);
          chk("R5 tx_len", 32'(tx_len), 32'(exp_len));
          chk("R5 tx_pad", 32'(tx_pad), 32'(exp_pad));
          chk("R5 tx_crc", 32'(tx_crc), 32'(exp_crc));
        end
      end
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 tx_req", 32'(tx_req), 32'd0);
    chk("R1 irq", 32'(irq), 32'd0);
    read_chk("R1 ctrl", 12'h000, 32'd0);
    read_chk("R1 source", 12'h004, 32'd0);
    read_chk("R1 mask", 12'h008, 32'd0);
    read_chk("R1 count", 12'h00C, 32'd0);

    for (int i = 0; i < NB; i++) begin
      bus_write(12'h400 + 12'(8 * i), 32'd0);
      bus_write(12'h404 + 12'(8 * i), 32'd0);
    end

    // R2 table access
    bus_write(12'h428, 32'h0040_0000);
    bus_write(12'h42C, 32'hDEAD_BEEF);
    read_chk("R2 status word", 12'h428, 32'h0040_0000);
    read_chk("R2 address word", 12'h42C, 32'hDEAD_BEEF);
    bus_write(12'h448, 32'h1234_5678);
    read_chk("R2 beyond table", 12'h448, 32'd0);
    read_chk("R2 entry 1 untouched", 12'h408, 32'd0);

    // R3 clamp
    bus_write(12'h00C, 32'd100);
    read_chk("R3 clamp", 12'h00C, 32'd8);
    bus_write(12'h00C, 32'd3);
    read_chk("R3 store", 12'h00C, 32'd3);

    // R4 disabled: ready descriptor not served
    bus_write(12'h008, 32'd3);
    expect_frame(32'h0000_1000, 16'd60, 1'b1, 1'b1);
    bus_write(12'h404, 32'h0000_1000);
    bus_write(12'h400, 32'h003C_D800);
    exp_on = 1'b0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      chk("R4 no start while disabled", 32'(tx_req), 32'd0);
    end
    read_chk("R4 descriptor unchanged", 12'h400, 32'h003C_D800);

    // R5/R6/R7/R8: frame 0, non-error result
    exp_on = 1'b1;
    bus_write(12'h000, 32'h0000_0002);
    wait_req("R5 start desc0");
    finish_frame(9'h012, 1'b1);
    repeat (3) @(negedge clk);
    read_chk("R7 writeback desc0", 12'h400, 32'h003C_5812);
    read_chk("R8 sent source", 12'h004, 32'd1);
    chk("R11 irq set", 32'(irq), 32'd1);

    // R9 write-one-to-clear
    bus_write(12'h004, 32'd0);
    read_chk("R9 zero write keeps", 12'h004, 32'd1);
    bus_write(12'h004, 32'd1);
    read_chk("R9 cleared", 12'h004, 32'd0);
    chk("R11 irq cleared", 32'(irq), 32'd0);

    // R8 no irq enable, R12 step to index 1
    expect_frame(32'h0000_2000, 16'd1500, 1'b0, 1'b1);
    bus_write(12'h40C, 32'h0000_2000);
    bus_write(12'h408, 32'h05DC_8800);
    wait_req("R12 next index 1");
    finish_frame(9'h100, 1'b0);
    repeat (3) @(negedge clk);
    read_chk("R8 source unchanged", 12'h004, 32'd0);
    read_chk("R7 writeback desc1", 12'h408, 32'h05DC_0900);

    // R10 error classification, R11 masking
    bus_write(12'h008, 32'd1);
    expect_frame(32'h0000_3000, 16'd100, 1'b0, 1'b0);
    bus_write(12'h414, 32'h0000_3000);
    bus_write(12'h410, 32'h0064_C000);
    wait_req("R12 next index 2");
    finish_frame(9'h008, 1'b1);
    repeat (3) @(negedge clk);
    read_chk("R10 error source", 12'h004, 32'd2);
    chk("R11 masked off", 32'(irq), 32'd0);
    bus_write(12'h008, 32'd3);
    @(negedge clk);
    chk("R11 unmasked", 32'(irq), 32'd1);
    bus_write(12'h004, 32'd3);

    // R12 last index returns to 0, then wrap bit
    bus_write(12'h40C, 32'h0000_6000);
    bus_write(12'h408, 32'h0040_8000);
    expect_frame(32'h0000_4000, 16'd80, 1'b0, 1'b0);
    bus_write(12'h404, 32'h0000_4000);
    bus_write(12'h400, 32'h0050_A000);
    wait_req("R12 return after last");
    finish_frame(9'h000, 1'b0);
    expect_frame(32'h0000_5000, 16'd90, 1'b0, 1'b0);
    bus_write(12'h404, 32'h0000_5000);
    bus_write(12'h400, 32'h005A_A000);
    wait_req("R12 wrap bit");
    finish_frame(9'h000, 1'b0);
    bus_write(12'h408, 32'h0000_0000);
    read_chk("R12 desc1 skipped", 12'h408, 32'h0000_0000);

    // R13 entry beyond the ring
    bus_write(12'h41C, 32'h0000_7000);
    bus_write(12'h418, 32'h0040_8000);
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      chk("R13 not served", 32'(tx_req), 32'd0);
    end
    read_chk("R13 still ready", 12'h418, 32'h0040_8000);

    summary();
    $finish;
  end
endmodule